// File: doc/BRIEF.md
# SD Single-Line Block Data Engine

This engine moves block-structured data between a byte-wide FIFO port and the single serial data line of an SD card. One start request carries the transfer length in bytes, a wait limit in clock cycles, the direction, and the block size given as a power of two. The engine then splits the length into blocks. It frames or deframes each block on the line and keeps a live count of the bytes still to move. It stops on the first fatal error.

On writes it drives a start bit, then the payload, then a 16-bit CRC, then a stop bit. It then releases the line, reads the card's three-bit acceptance token and waits out the busy period. On reads it waits for the card's start bit, passes each byte to the FIFO side, and checks the trailing CRC. Five sticky flags record the result: completion, CRC failure, wait-limit expiry, receive overflow and transmit starvation. Each flag is cleared by writing a one. A masked OR of the flags forms the interrupt line.

Top module: `sdd_data_path`

## Requirements
- R1: After reset the line is released (`dat_oe`=0), `tx_active`, `rx_active`, `rx_valid`, `tx_ready` and `irq` are 0, and `status` is 0.
- R2: A pulse on `ctl_wr` with `ctl_en`=1 starts a transfer only when the engine is idle. `ctl_dir`=1 selects a read (card to engine) and 0 selects a write. `ctl_lg` is log2 of the block size. A request made while a transfer runs has no effect.
- R3: A written block goes out one bit per clock. The order is a 0 start bit, the bytes MSB first, the CRC16 (polynomial x^16+x^12+x^5+1, initial value 0) MSB first, and a 1 stop bit. `dat_oe` is high only during these bits.
- R4: After a written block the engine samples a 0 start bit and three token bits, MSB first. Token 010 means accepted. Any other token sets the CRC-fail flag and ends the transfer. Once accepted, `tx_active` stays high while the card holds the line low, and the block finishes on the first high sample.
- R5: On a read the engine waits for a 0 start bit. It shifts in bytes MSB first and presents each one on `rx_data` with a one-cycle `rx_valid`. It then checks the 16 CRC bits and skips the stop bit. A CRC mismatch sets the CRC-fail flag and ends the transfer.
- R6: `bytes_left` is loaded with the programmed length at start. It drops by one for each byte taken from the FIFO (write) or delivered (read). A start with length 0 sets the completion flag at once, with no line activity.
- R7: Each block holds 2^`ctl_lg` bytes, limited by MAX_LOG2. The last block carries the remainder when the length is not a multiple of the block size.
- R8: While waiting for a read start bit, a token start bit or the end of busy, the wait counter is loaded with `tmo_in` and counts down. If the line has not moved after `tmo_in`+1 cycles of waiting, status bit 1 is set and the transfer ends.
- R9: If a byte is needed on a write while `tx_valid` is low, status bit 2 (underrun) is set, the line is released and the transfer ends.
- R10: If `rx_valid` is high while `rx_ready` is low, status bit 3 (overrun) is set and that byte is lost. The transfer continues.
- R11: The status bit positions are 0 CRC fail, 1 timeout, 2 underrun, 3 overrun, 4 completion. A status bit stays set until a 1 is written on the same bit of `clr_in`. `irq` is the OR of `status & mask_in`.
- R12: Status bit 4 (completion) is set when every programmed byte has moved: on a write when the last block's busy period ends, and on a read after the last block's CRC passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Start request strobe |
| ctl_en | input | 1 | Enable field of the request |
| ctl_dir | input | 1 | 1 = read, 0 = write |
| ctl_lg | input | 4 | log2 of the block size |
| len_in | input | 16 | Transfer length in bytes |
| tmo_in | input | 32 | Wait limit in clock cycles |
| mask_in | input | 5 | Interrupt mask per status bit |
| clr_in | input | 5 | Write-one-to-clear per status bit |
| tx_data | input | 8 | Byte from the transmit FIFO |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte present (one cycle) |
| rx_ready | input | 1 | Receive FIFO can accept |
| dat_in | input | 1 | Sampled data line |
| dat_out | output | 1 | Driven data line value |
| dat_oe | output | 1 | Line drive enable |
| bytes_left | output | 16 | Bytes still to move |
| tx_active | output | 1 | Write in progress, busy included |
| rx_active | output | 1 | Read in progress |
| status | output | 5 | Sticky flags |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench keeps the default widths (16-bit length, 32-bit wait counter, MAX_LOG2 of 11). It programs block sizes of 4 bytes through the log2 field, so multi-block transfers and a short final block fit into a few hundred cycles. It also uses a 20-cycle wait limit, which makes the exact expiry cycle of the timeout observable. With these short settings the bench can reach a mid-transfer restart attempt, a rejected token, a starved FIFO, a corrupted read CRC, a stalled receive side and a zero-length start within one run.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WSTART, ST_WDATA, ST_WCRC, ST_WEND,
    ST_WTOK, ST_WTOKB, ST_WTOKE, ST_WBUSY,
    ST_RWAIT, ST_RDATA, ST_RCRC, ST_REND
  } sdd_state_e;

  localparam int NFLAGS   = 5;
  localparam int FL_CRC   = 0;
  localparam int FL_TMO   = 1;
  localparam int FL_UNDR  = 2;
  localparam int FL_OVR   = 3;
  localparam int FL_END   = 4;

  localparam logic [2:0] TOKEN_OK = 3'b010;

  // one serial step of x^16+x^12+x^5+1
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

endpackage

// File: rtl/sdd_crc16.sv
module sdd_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        shift,
  input  logic        bit_in,
  output logic [15:0] crc
);
  import sdd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= '0;
    else if (clr)    crc <= '0;
    else if (en)     crc <= crc16_step(crc, bit_in);
    else if (shift)  crc <= {crc[14:0], 1'b0};
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en && !shift) |=> $stable(crc)); // R3
endmodule

// File: rtl/sdd_timer.sv
module sdd_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt))); // R8
endmodule

// File: rtl/sdd_status.sv
module sdd_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr) | set;
  end

  assign irq = |(stat & mask);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((stat & $past(stat)) == $past(stat))); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((stat & $past(set)) == $past(set))); // R11
endmodule

// File: rtl/sdd_data_path.sv
module sdd_data_path #(
  parameter int LEN_W    = 16,
  parameter int TMR_W    = 32,
  parameter int MAX_LOG2 = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_wr,
  input  logic                      ctl_en,
  input  logic                      ctl_dir,
  input  logic [3:0]                ctl_lg,
  input  logic [LEN_W-1:0]          len_in,
  input  logic [TMR_W-1:0]          tmo_in,
  input  logic [sdd_pkg::NFLAGS-1:0] mask_in,
  input  logic [sdd_pkg::NFLAGS-1:0] clr_in,
  input  logic [7:0]                tx_data,
  input  logic                      tx_valid,
  output logic                      tx_ready,
  output logic [7:0]                rx_data,
  output logic                      rx_valid,
  input  logic                      rx_ready,
  input  logic                      dat_in,
  output logic                      dat_out,
  output logic                      dat_oe,
  output logic [LEN_W-1:0]          bytes_left,
  output logic                      tx_active,
  output logic                      rx_active,
  output logic [sdd_pkg::NFLAGS-1:0] status,
  output logic                      irq
);
  import sdd_pkg::*;

  localparam int LG_CAP = (MAX_LOG2 > 15) ? 15 : MAX_LOG2;

  // bytes in the next block: 2^lg capped, or what remains
  function automatic logic [LEN_W-1:0] blk_take(input logic [3:0] lg,
                                                input logic [LEN_W-1:0] rem);
    logic [3:0]   l;
    logic [LEN_W:0] sz;
    l  = (int'(lg) > LG_CAP) ? 4'(LG_CAP) : lg;
    sz = (LEN_W+1)'(1) << l;
    return ({1'b0, rem} < sz) ? rem : sz[LEN_W-1:0];
  endfunction

  sdd_state_e         state;
  logic [7:0]         shreg;
  logic [3:0]         bitcnt;
  logic [LEN_W-1:0]   blk_bytes;
  logic [LEN_W-1:0]   remaining;
  logic [3:0]         lg_q;
  logic [2:0]         tok;
  logic [7:0]         rx_data_q;
  logic               rx_valid_q;
  logic [15:0]        crc;

  // named internal events
  logic               start_ok;
  logic               wait_state;
  logic               line_idle;
  logic               timer_run;
  logic               timer_load;
  logic               timer_exp;
  logic               tmo_hit;
  logic               crc_clr, crc_en, crc_shift, crc_bit;
  logic [LEN_W-1:0]   blk_first;
  logic [NFLAGS-1:0]  set_flags;

  assign start_ok  = ctl_wr && ctl_en && (state == ST_IDLE);
  assign blk_first = blk_take(lg_q, remaining);

  assign tx_active = (state inside {ST_WSTART, ST_WDATA, ST_WCRC, ST_WEND,
                                    ST_WTOK, ST_WTOKB, ST_WTOKE, ST_WBUSY});
  assign rx_active = (state inside {ST_RWAIT, ST_RDATA, ST_RCRC, ST_REND});

  assign tx_ready = (state == ST_WSTART) ||
                    ((state == ST_WDATA) && (bitcnt == 4'd0) && (blk_bytes != '0));

  assign dat_oe = (state inside {ST_WSTART, ST_WDATA, ST_WCRC, ST_WEND});

  always_comb begin
    case (state)
      ST_WDATA: dat_out = shreg[7];
      ST_WCRC:  dat_out = crc[15];
      ST_WSTART: dat_out = 1'b0;
      default:  dat_out = 1'b1;
    endcase
  end

  // waiting on the card: start bit, token start or busy release
  assign wait_state = (state inside {ST_WTOK, ST_WBUSY, ST_RWAIT});
  assign line_idle  = (state == ST_WBUSY) ? !dat_in : dat_in;
  assign timer_run  = wait_state && line_idle;
  assign tmo_hit    = timer_run && timer_exp;
  assign timer_load = start_ok || (state == ST_WEND) || (state == ST_WTOKE) ||
                      (state == ST_REND);

  sdd_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (tmo_in),
    .run      (timer_run),
    .expired  (timer_exp)
  );

  assign crc_clr   = (state == ST_WSTART) || (state == ST_RWAIT);
  assign crc_en    = (state inside {ST_WDATA, ST_RDATA, ST_RCRC});
  assign crc_shift = (state == ST_WCRC);
  assign crc_bit   = (state == ST_WDATA) ? shreg[7] : dat_in;

  sdd_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (crc_clr),
    .en     (crc_en),
    .shift  (crc_shift),
    .bit_in (crc_bit),
    .crc    (crc)
  );

  always_comb begin
    set_flags          = '0;
    set_flags[FL_CRC]  = ((state == ST_WTOKE) && (tok != TOKEN_OK)) ||
                         ((state == ST_REND) && (crc != 16'h0000));
    set_flags[FL_TMO]  = tmo_hit;
    set_flags[FL_UNDR] = tx_ready && !tx_valid;
    set_flags[FL_OVR]  = rx_valid_q && !rx_ready;
    set_flags[FL_END]  = (start_ok && (len_in == '0)) ||
                         ((state == ST_WBUSY) && dat_in && (remaining == '0)) ||
                         ((state == ST_REND) && (crc == 16'h0000) && (remaining == '0));
  end

  sdd_status #(.N(NFLAGS)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_flags),
    .clr   (clr_in),
    .mask  (mask_in),
    .stat  (status),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      blk_bytes  <= '0;
      remaining  <= '0;
      lg_q       <= '0;
      tok        <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            remaining <= len_in;
            lg_q      <= ctl_lg;
            if (len_in != '0) state <= ctl_dir ? ST_RWAIT : ST_WSTART;
          end
        end
        ST_WSTART: begin
          if (tx_valid) begin
            shreg     <= tx_data;
            bitcnt    <= 4'd7;
            blk_bytes <= blk_first - 1'b1;
            remaining <= remaining - 1'b1;
            state     <= ST_WDATA;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WDATA: begin
          if (bitcnt != 4'd0) begin
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt - 1'b1;
          end else if (blk_bytes != '0) begin
            if (tx_valid) begin
              shreg     <= tx_data;
              bitcnt    <= 4'd7;
              blk_bytes <= blk_bytes - 1'b1;
              remaining <= remaining - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            bitcnt <= 4'd15;
            state  <= ST_WCRC;
          end
        end
        ST_WCRC: begin
          if (bitcnt == 4'd0) state <= ST_WEND;
          else                bitcnt <= bitcnt - 1'b1;
        end
        ST_WEND: state <= ST_WTOK;
        ST_WTOK: begin
          if (!dat_in) begin
            bitcnt <= 4'd2;
            state  <= ST_WTOKB;
          end else if (tmo_hit) begin
            state <= ST_IDLE;
          end
        end
        ST_WTOKB: begin
          tok <= {tok[1:0], dat_in};
          if (bitcnt == 4'd0) state <= ST_WTOKE;
          else                bitcnt <= bitcnt - 1'b1;
        end
        ST_WTOKE: state <= (tok == TOKEN_OK) ? ST_WBUSY : ST_IDLE;
        ST_WBUSY: begin
          if (dat_in)       state <= (remaining == '0) ? ST_IDLE : ST_WSTART;
          else if (tmo_hit) state <= ST_IDLE;
        end
        ST_RWAIT: begin
          if (!dat_in) begin
            bitcnt    <= 4'd7;
            blk_bytes <= blk_first;
            state     <= ST_RDATA;
          end else if (tmo_hit) begin
            state <= ST_IDLE;
          end
        end
        ST_RDATA: begin
          shreg <= {shreg[6:0], dat_in};
          if (bitcnt == 4'd0) begin
            rx_data_q  <= {shreg[6:0], dat_in};
            rx_valid_q <= 1'b1;
            remaining  <= remaining - 1'b1;
            bitcnt     <= 4'd7;
            if (blk_bytes == 1) begin
              bitcnt <= 4'd15;
              state  <= ST_RCRC;
            end else begin
              blk_bytes <= blk_bytes - 1'b1;
            end
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        ST_RCRC: begin
          if (bitcnt == 4'd0) state <= ST_REND;
          else                bitcnt <= bitcnt - 1'b1;
        end
        ST_REND: begin
          if (crc != 16'h0000)        state <= ST_IDLE;
          else if (remaining == '0)   state <= ST_IDLE;
          else                        state <= ST_RWAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rx_data    = rx_data_q;
  assign rx_valid   = rx_valid_q;
  assign bytes_left = remaining;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_active && rx_active)); // R2
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> tx_active); // R3
  AST_LEFT_NONINCREASING: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_active || rx_active) && $past(tx_active || rx_active)) |->
      (bytes_left <= $past(bytes_left))); // R6
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_TXREADY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_active); // R9
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags[FL_END] |=> (bytes_left == '0)); // R12
endmodule

// File: tb/tb_sdd_data_path.sv
module tb_sdd_data_path;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, ctl_wr, ctl_en, ctl_dir;
  logic [3:0]  ctl_lg;
  logic [15:0] len_in;
  logic [31:0] tmo_in;
  logic [4:0]  mask_in, clr_in;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_ready;
  logic        dat_in, dat_out, dat_oe;
  logic [15:0] bytes_left;
  logic        tx_active, rx_active, irq;
  logic [4:0]  status;

  sdd_data_path dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dir(ctl_dir),
    .ctl_lg(ctl_lg), .len_in(len_in), .tmo_in(tmo_in), .mask_in(mask_in),
    .clr_in(clr_in), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .dat_in(dat_in),
    .dat_out(dat_out), .dat_oe(dat_oe), .bytes_left(bytes_left),
    .tx_active(tx_active), .rx_active(rx_active), .status(status), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural model state
  logic [7:0] txq [0:15];
  logic [7:0] card [0:15];
  int  tx_n = 0, tx_idx = 0, tx_base = 0;
  bit  tx_en = 0;
  int  rx_seen = 0, rx_base = 0;
  logic [7:0] rxgot[$];
  bit  expq[$];
  bit  mon_on = 0, mon_dir = 0;
  int  mon_len = 0;

  assign tx_valid = tx_en && ((tx_idx - tx_base) < tx_n);
  assign tx_data  = ((tx_idx - tx_base) < 16) ? txq[tx_idx - tx_base] : 8'h00;

  always @(posedge clk) if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rx_valid) begin
      rx_seen++;
      if (rx_ready) rxgot.push_back(rx_data);
    end
    if (dat_oe) begin
      if (expq.size() == 0) chk("R3", "driven bit beyond frame", 1, 0);
      else chk("R3", "serial bit", dat_out, expq.pop_front());
    end
    if (mon_on)
      chk("R6", "bytes_left", bytes_left,
          mon_len - (mon_dir ? (rx_seen - rx_base) : (tx_idx - tx_base)));
  end

  function automatic logic [15:0] crc_ref(input logic [7:0] b [0:15], input int off, input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      c = c ^ {b[off+i], 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic push_frame(input int off, input int n);
    logic [15:0] c;
    c = crc_ref(txq, off, n);
    expq.push_back(1'b0);
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) expq.push_back(txq[off+i][k]);
    for (int k = 15; k >= 0; k--) expq.push_back(c[k]);
    expq.push_back(1'b1);
  endtask

  task automatic start(input bit dir, input int lg, input int len, input int tmo);
    @(negedge clk);
    ctl_en = 1; ctl_dir = dir; ctl_lg = 4'(lg); len_in = 16'(len); tmo_in = tmo;
    ctl_wr = 1; mon_len = len; mon_dir = dir; tx_base = tx_idx; rx_base = rx_seen;
    rxgot.delete();
    @(negedge clk);
    ctl_wr = 0; mon_on = 1;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_in = 5'h1f;
    @(negedge clk); clr_in = 5'h00;
  endtask

  // card side of a written block: token then busy
  task automatic card_wblk(input logic [2:0] tk, input int busy);
    bit seen = 0;
    do begin
      @(negedge clk);
      if (dat_oe) seen = 1;
    end while (!(seen && !dat_oe));
    dat_in = 1'b1; @(negedge clk);
    dat_in = 1'b0; @(negedge clk);
    for (int k = 2; k >= 0; k--) begin dat_in = tk[k]; @(negedge clk); end
    dat_in = 1'b1; @(negedge clk);
    for (int i = 0; i < busy; i++) begin
      dat_in = 1'b0; @(negedge clk);
      if (i > 0) chk("R4", "tx_active during busy", tx_active, 1);
    end
    dat_in = 1'b1;
  endtask

  // card side of a read block
  task automatic card_rblk(input int off, input int n, input bit corrupt);
    logic [15:0] c;
    c = crc_ref(card, off, n) ^ {15'h0, corrupt};
    dat_in = 1'b1; repeat (2) @(negedge clk);
    dat_in = 1'b0; @(negedge clk);
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) begin dat_in = card[off+i][k]; @(negedge clk); end
    for (int k = 15; k >= 0; k--) begin dat_in = c[k]; @(negedge clk); end
    dat_in = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 0; ctl_wr = 0; ctl_en = 0; ctl_dir = 0; ctl_lg = 0; len_in = 0;
    tmo_in = 0; mask_in = 0; clr_in = 0; rx_ready = 1; dat_in = 1;
    for (int i = 0; i < 16; i++) begin
      txq[i]  = 8'(8'h5A + i * 37);
      card[i] = 8'(8'hC3 ^ (i * 29));
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "dat_oe", dat_oe, 0);
    chk("R1", "tx_active", tx_active, 0);
    chk("R1", "rx_active", rx_active, 0);
    chk("R1", "status", status, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "tx_ready/rx_valid", {tx_ready, rx_valid}, 0);

    // Write 6 bytes in 4-byte blocks (R3 R7), request mid-transfer ignored (R2)
    tx_n = 6; tx_en = 1;
    push_frame(0, 4); push_frame(4, 2);
    start(0, 2, 6, 1000);
    fork
      begin card_wblk(3'b010, 3); card_wblk(3'b010, 0); end
      begin
        repeat (12) @(negedge clk);
        ctl_dir = 1; len_in = 16'd99; ctl_wr = 1;
        @(negedge clk); ctl_wr = 0;
        chk("R2", "rx_active after ignored request", rx_active, 0);
        chk("R2", "tx_active after ignored request", tx_active, 1);
      end
    join
    settle();
    chk("R3", "frame bits remaining", expq.size(), 0);
    chk("R7", "bytes taken", tx_idx - tx_base, 6);
    chk("R12", "completion flag", status[4], 1);
    chk("R4", "tx_active after busy", tx_active, 0);
    chk("R6", "bytes_left at end", bytes_left, 0);
    mask_in = 5'h10; #1;
    chk("R11", "irq masked on", irq, 1);
    mask_in = 5'h0f; #1;
    chk("R11", "irq masked off", irq, 0);
    @(negedge clk); clr_in = 5'h01;
    @(negedge clk); clr_in = 5'h00;
    chk("R11", "wrong clear bit keeps flag", status[4], 1);
    @(negedge clk); clr_in = 5'h10;
    @(negedge clk); clr_in = 5'h00;
    chk("R11", "flag cleared", status, 0);
    mask_in = 0; tx_en = 0;

    // Rejected token (R4)
    tx_n = 4; tx_en = 1;
    push_frame(0, 4);
    start(0, 2, 4, 1000);
    card_wblk(3'b101, 0);
    settle();
    chk("R4", "crc-fail on bad token", status[0], 1);
    chk("R4", "no completion", status[4], 0);
    chk("R4", "stopped", tx_active, 0);
    clear_all(); tx_en = 0;

    // Underrun (R9)
    tx_n = 2; tx_en = 1;
    expq.push_back(1'b0);
    for (int i = 0; i < 2; i++)
      for (int k = 7; k >= 0; k--) expq.push_back(txq[i][k]);
    start(0, 2, 4, 1000);
    repeat (30) @(negedge clk);
    settle();
    chk("R9", "underrun flag", status[2], 1);
    chk("R9", "line released", dat_oe, 0);
    chk("R9", "stopped", tx_active, 0);
    chk("R9", "frame bits remaining", expq.size(), 0);
    clear_all(); tx_en = 0;

    // Good read, 5 bytes in 4-byte blocks (R5 R7 R12)
    start(1, 2, 5, 1000);
    card_rblk(0, 4, 0);
    card_rblk(4, 1, 0);
    settle();
    chk("R5", "bytes received", rxgot.size(), 5);
    for (int i = 0; i < 5; i++)
      if (i < rxgot.size()) chk("R5", "rx byte", rxgot[i], card[i]);
    chk("R12", "read completion", status[4], 1);
    chk("R5", "no crc fail", status[0], 0);
    clear_all();

    // Corrupted CRC on read (R5)
    start(1, 2, 3, 1000);
    card_rblk(0, 3, 1);
    settle();
    chk("R5", "crc fail flagged", status[0], 1);
    chk("R5", "no completion", status[4], 0);
    chk("R5", "stopped", rx_active, 0);
    clear_all();

    // Overrun (R10)
    rx_ready = 0;
    start(1, 2, 2, 1000);
    card_rblk(0, 2, 0);
    settle();
    chk("R10", "overrun flag", status[3], 1);
    chk("R10", "transfer still completed", status[4], 1);
    chk("R10", "bytes lost", rxgot.size(), 0);
    rx_ready = 1;
    clear_all();

    // Timeout on read start (R8)
    start(1, 2, 4, 20);
    repeat (20) @(negedge clk);
    chk("R8", "no timeout before limit", status[1], 0);
    @(negedge clk);
    chk("R8", "timeout at limit", status[1], 1);
    chk("R8", "stopped", rx_active, 0);
    settle();
    clear_all();

    // Zero length (R6)
    start(0, 2, 0, 1000);
    chk("R6", "zero length completes", status[4], 1);
    chk("R6", "zero length no activity", tx_active, 0);
    settle();
    chk("R6", "no line drive", dat_oe, 0);

    report();
  end
endmodule